// File: doc/BRIEF.md
# Serial Port Interrupt Priority and Identification

This block gathers the four interrupt causes of a serial port and reduces them to one interrupt request line and one identification byte that host software reads to learn why it was interrupted. The causes are receiver line status, received data available, transmitter holding register empty and modem status. A receive time-out condition is folded in with received data. A 4-bit enable register, written over a small host bus, gates each cause. The highest-priority cause that is both raised and enabled is encoded into the identification byte. The same byte also reports whether the FIFOs are switched on.

The transmitter-empty cause arrives as a one-cycle set pulse. The block holds it as pending until the host reads the identification byte while that byte reports transmitter-empty. The other causes are level flags, and the logic that produces them clears them from outside. The identification byte is registered: every change in the inputs or the enable register appears one clock edge later.

Top module: `uart_irq_ident`

## Requirements
- R1: After synchronous reset the enable register reads 0x0, the identification byte reads 0x01 and the interrupt request line is low.
- R2: A host write to address 1 stores write-data bits [3:0] in the enable register. A read at address 1 returns those four bits with bits [7:4] zero. The enable bits are: bit 0 received data (and time-out), bit 1 transmitter empty, bit 2 line status, bit 3 modem status.
- R3: A cause takes part in resolution only when its flag and its enable bit are both 1. When no cause takes part, identification bit 0 is 1 and bits [3:1] are 000.
- R4: Identification bit 0 is 0 while any enabled cause is pending. Bits [2:1] name the winning cause: 11 line status, 10 received data, 01 transmitter empty, 00 modem status. Priority runs in that order, highest first.
- R5: An enabled time-out sets identification bit 3 and reports code 10, at the same priority as received data. A line status cause overrides it and clears bit 3.
- R6: Identification bits [7:6] read 11 while the FIFO-on input is 1 and 00 while it is 0. Bits [5:4] always read 0.
- R7: A host write to the identification address (address 2) changes neither the identification byte nor the enable register.
- R8: The interrupt request output is the inverse of identification bit 0.
- R9: A one-cycle transmitter-empty pulse is held as pending. A host read at address 2, made while the byte reports code 01 with bit 0 at 0, clears it. A read made while another cause is reported does not clear it.
- R10: The identification byte, the interrupt line and the enable read-back change on the first clock edge after the stimulus that causes the change, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W (3) | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the addressed register |
| evt_line | input | 1 | Receiver line status flag |
| evt_rxdata | input | 1 | Received data available flag |
| evt_txempty | input | 1 | Transmitter holding empty set pulse |
| evt_modem | input | 1 | Modem status change flag |
| evt_timeout | input | 1 | Receive time-out flag |
| fifo_on | input | 1 | FIFOs enabled and working |
| irq | output | 1 | Interrupt request, high while pending |
| id_word | output | 8 | Identification byte |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. This holds for the identification byte, the interrupt line and the register read-back. It also holds for the transmitter-empty pulse and for the clearing read, because the byte is built from the next state of the pending latch. The driver applies each stimulus on a falling edge and queues the expected byte for the next rising edge. The monitor compares a quarter period after that rising edge, while the driven address is still held. One extra check samples the byte just after a stimulus is applied, to confirm it has not yet moved.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int EN_W   = 4;
    localparam int N_SRC  = 4;

    // enable register bit positions
    localparam int EN_RXDATA  = 0;
    localparam int EN_TXEMPTY = 1;
    localparam int EN_LINE    = 2;
    localparam int EN_MODEM   = 3;

    // resolver request slots, index 0 is highest priority
    localparam int P_LINE    = 0;
    localparam int P_RXDATA  = 1;
    localparam int P_TXEMPTY = 2;
    localparam int P_MODEM   = 3;

    typedef enum logic [1:0] {
        SRC_MODEM   = 2'b00,
        SRC_TXEMPTY = 2'b01,
        SRC_RXDATA  = 2'b10,
        SRC_LINE    = 2'b11
    } src_code_e;

    typedef struct packed {
        logic [1:0] fifo_state;
        logic [1:0] rsvd;
        logic       tmo;
        src_code_e  code;
        logic       none_pending;
    } ident_t;

    localparam ident_t IDENT_RESET = '{
        fifo_state: 2'b00, rsvd: 2'b00, tmo: 1'b0,
        code: SRC_MODEM, none_pending: 1'b1
    };

    function automatic src_code_e grant_to_code(input logic [N_SRC-1:0] gnt);
        src_code_e c;
        c = SRC_MODEM;
        if (gnt[P_LINE])         c = SRC_LINE;
        else if (gnt[P_RXDATA])  c = SRC_RXDATA;
        else if (gnt[P_TXEMPTY]) c = SRC_TXEMPTY;
        return c;
    endfunction

endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic clr_pulse,
    output logic pend_d,
    output logic pend_q
);
    // a fresh event wins over a clearing read in the same cycle
    always_comb pend_d = set_pulse | (pend_q & ~clr_pulse);

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= pend_d;
    end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    logic [N:0] blocked;
    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign gnt[i]       = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end

    assign any = blocked[N];
endmodule

// File: rtl/irq_ident_build.sv
module irq_ident_build
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] gnt,
    input  logic             any,
    input  logic             tmo_active,
    input  logic             fifo_on,
    output ident_t           id_q,
    output logic             irq_q
);
    ident_t id_d;

    always_comb begin
        id_d              = IDENT_RESET;
        id_d.fifo_state   = fifo_on ? 2'b11 : 2'b00;
        id_d.none_pending = ~any;
        id_d.code         = grant_to_code(gnt);
        id_d.tmo          = gnt[P_RXDATA] & tmo_active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q  <= IDENT_RESET;
            irq_q <= 1'b0;
        end else begin
            id_q  <= id_d;
            irq_q <= |gnt;
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int ENA_ADDR = 1,
    parameter int ID_ADDR  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              evt_line,
    input  logic              evt_rxdata,
    input  logic              evt_txempty,
    input  logic              evt_modem,
    input  logic              evt_timeout,
    input  logic              fifo_on,
    output logic              irq,
    output logic [7:0]        id_word
);
    localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(ENA_ADDR);
    localparam logic [ADDR_W-1:0] A_ID  = ADDR_W'(ID_ADDR);

    logic [EN_W-1:0]  ena_q, ena_d;
    logic             ena_wr, tx_clr, tx_pend_d, tx_pend_q;
    logic [N_SRC-1:0] req, gnt;
    logic             any;
    ident_t           id_q;
    logic             irq_q;
    logic             unused_wd;

    assign unused_wd = ^host_wdata[7:EN_W];

    // enable register, next state also feeds resolution
    assign ena_wr = host_wr && (host_addr == A_ENA);
    assign ena_d  = ena_wr ? host_wdata[EN_W-1:0] : ena_q;

    always_ff @(posedge clk) begin
        if (rst) ena_q <= '0;
        else     ena_q <= ena_d;
    end

    // reading the byte while it names transmitter-empty retires that event
    assign tx_clr = host_rd && (host_addr == A_ID) &&
                    !id_q.none_pending && (id_q.code == SRC_TXEMPTY);

    irq_event_latch u_tx_latch (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (evt_txempty),
        .clr_pulse (tx_clr),
        .pend_d    (tx_pend_d),
        .pend_q    (tx_pend_q)
    );

    always_comb begin
        req            = '0;
        req[P_LINE]    = evt_line  & ena_d[EN_LINE];
        req[P_RXDATA]  = (evt_rxdata | evt_timeout) & ena_d[EN_RXDATA];
        req[P_TXEMPTY] = tx_pend_d & ena_d[EN_TXEMPTY];
        req[P_MODEM]   = evt_modem & ena_d[EN_MODEM];
    end

    irq_prio_resolve #(.N(N_SRC)) u_resolve (
        .req (req),
        .gnt (gnt),
        .any (any)
    );

    irq_ident_build u_build (
        .clk        (clk),
        .rst        (rst),
        .gnt        (gnt),
        .any        (any),
        .tmo_active (evt_timeout & ena_d[EN_RXDATA]),
        .fifo_on    (fifo_on),
        .id_q       (id_q),
        .irq_q      (irq_q)
    );

    assign id_word = id_q;
    assign irq     = irq_q;

    always_comb begin
        if (host_addr == A_ID)       host_rdata = id_q;
        else if (host_addr == A_ENA) host_rdata = {{(8-EN_W){1'b0}}, ena_q};
        else                         host_rdata = 8'h00;
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int ADDR_W   = 3,
    parameter int ID_ADDR  = 2,
    parameter int ENA_ADDR = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              evt_line,
    input logic              fifo_on,
    input logic              irq,
    input logic [7:0]        id_word,
    input logic [3:0]        ena_q
);
    a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (id_word == 8'h01 && !irq));

    a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
        irq == !id_word[0]);

    a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        id_word[5:4] == 2'b00);

    a_r6_fifo_on: assert property (@(posedge clk) disable iff (rst)
        fifo_on |=> id_word[7:6] == 2'b11);

    a_r6_fifo_off: assert property (@(posedge clk) disable iff (rst)
        !fifo_on |=> id_word[7:6] == 2'b00);

    a_r4_line_top: assert property (@(posedge clk) disable iff (rst)
        (evt_line && ena_q[2] && !host_wr) |=> id_word[3:0] == 4'b0110);

    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (ena_q == 4'h0 && !host_wr) |=> id_word[3:0] == 4'b0001);

    a_r7_id_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == ADDR_W'(ID_ADDR)) |=> $stable(ena_q));

    a_r5_tmo_code: assert property (@(posedge clk) disable iff (rst)
        id_word[3] |-> id_word[2:0] == 3'b100);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(
    .ADDR_W(ADDR_W), .ID_ADDR(ID_ADDR), .ENA_ADDR(ENA_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .evt_line(evt_line), .fifo_on(fifo_on), .irq(irq),
    .id_word(id_word), .ena_q(ena_q)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    localparam int CLK_P = 10;
    localparam logic [2:0] A_ENA = 3'd1;
    localparam logic [2:0] A_ID  = 3'd2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       evt_line = 0, evt_rxdata = 0, evt_txempty = 0;
    logic       evt_modem = 0, evt_timeout = 0, fifo_on = 0;
    logic       irq;
    logic [7:0] id_word;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] id;
        bit         chk_rd;
        logic [7:0] rd;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    uart_irq_ident u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_line(evt_line), .evt_rxdata(evt_rxdata), .evt_txempty(evt_txempty),
        .evt_modem(evt_modem), .evt_timeout(evt_timeout), .fifo_on(fifo_on),
        .irq(irq), .id_word(id_word)
    );

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // driver: queue the result expected after the coming rising edge
    task automatic expect_next(logic [7:0] id, bit chk_rd, logic [7:0] rd, string tag);
        exp_t e;
        e.id = id; e.chk_rd = chk_rd; e.rd = rd; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check8({e.tag, " id"}, id_word, e.id);
            check8({e.tag, " irq R8"}, {7'b0, irq}, {7'b0, ~e.id[0]});
            if (e.chk_rd) check8({e.tag, " rdata"}, host_rdata, e.rd);
        end
    end

    initial begin : watchdog
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        host_addr = A_ENA;
        #1;
        check8("R1 reset id", id_word, 8'h01);
        check8("R1 reset irq", {7'b0, irq}, 8'h00);
        check8("R1 reset enable", host_rdata, 8'h00);
        @(negedge clk);

        // R2 enable write, upper bits dropped
        host_wr = 1; host_wdata = 8'hFF;
        expect_next(8'h01, 1, 8'h0F, "R2 enable write");
        host_wr = 0;

        // R4 each source code in turn
        evt_modem = 1;
        expect_next(8'h00, 0, 8'h00, "R4 modem");
        evt_txempty = 1;
        expect_next(8'h02, 0, 8'h00, "R4 R9 txempty pulse");
        evt_txempty = 0;
        expect_next(8'h02, 0, 8'h00, "R9 txempty held");
        evt_rxdata = 1;
        expect_next(8'h04, 0, 8'h00, "R4 rxdata");
        evt_line = 1;
        #1 check8("R10 not before edge", id_word, 8'h04);
        expect_next(8'h06, 0, 8'h00, "R4 line");

        // R9 read while line reported keeps txempty
        host_addr = A_ID; host_rd = 1;
        expect_next(8'h06, 1, 8'h06, "R9 read other source");
        host_rd = 0; evt_line = 0; evt_rxdata = 0;
        expect_next(8'h02, 0, 8'h00, "R9 txempty survives");
        host_rd = 1;
        expect_next(8'h00, 1, 8'h00, "R9 read clears txempty");
        host_rd = 0; evt_modem = 0;
        expect_next(8'h01, 0, 8'h00, "R3 idle");

        // R5 time-out
        evt_timeout = 1;
        expect_next(8'h0C, 0, 8'h00, "R5 timeout");
        evt_line = 1;
        expect_next(8'h06, 0, 8'h00, "R5 line overrides timeout");
        evt_line = 0; evt_timeout = 0; fifo_on = 1;
        expect_next(8'hC1, 0, 8'h00, "R6 fifo idle");
        evt_rxdata = 1;
        expect_next(8'hC4, 0, 8'h00, "R6 fifo rxdata");

        // R3 masking
        host_addr = A_ENA; host_wr = 1; host_wdata = 8'h00;
        expect_next(8'hC1, 1, 8'h00, "R3 disable all");
        host_wr = 0; evt_line = 1; evt_modem = 1; evt_txempty = 1;
        expect_next(8'hC1, 0, 8'h00, "R3 masked sources");
        evt_txempty = 0;

        // R7 write to identification address
        host_addr = A_ID; host_wr = 1; host_wdata = 8'hFF;
        expect_next(8'hC1, 1, 8'hC1, "R7 id write ignored");
        host_wr = 0; host_addr = A_ENA;
        expect_next(8'hC1, 1, 8'h00, "R7 enable untouched");

        // single enables
        host_wr = 1; host_wdata = 8'h04; fifo_on = 0;
        expect_next(8'h06, 1, 8'h04, "R2 R6 line only");
        host_wdata = 8'h08;
        expect_next(8'h00, 1, 8'h08, "R3 modem only");
        host_wdata = 8'h02;
        expect_next(8'h02, 1, 8'h02, "R9 masked pend kept");
        host_wr = 0;
        expect_next(8'h02, 0, 8'h00, "R9 still pending");

        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule